// File: doc/BRIEF.md
# Interruptible Iterative Divider

This block divides a 16-bit or 32-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. It supports unsigned integer, signed integer and signed fractional (1.15) division. It works one step at a time. A `start` pulse captures the operands and the mode. After that, each cycle with `step` high moves the operation forward by one stage. Exactly nineteen accepted steps complete a division.

Every partial value is held in registers. The step source may stop sending strobes for any number of cycles between two steps, for example while an interrupt is serviced, and then carry on. The final result is the same as for an unbroken run.

The schedule has four parts:

- one step that turns the operands into magnitudes and signs;
- sixteen non-restoring quotient steps;
- one step that corrects the remainder;
- one step that restores the signs and checks that the quotient fits.

Top module: `seq_divider`

## Requirements
- R1: A cycle with `start` high captures `dividend`, `divisor`, `wide`, `sgn` and `frac`. It raises `busy` on the next cycle with `done` low. It abandons any operation in progress, and the new operation again needs nineteen steps. When `start` and `step` are high in the same cycle, `start` wins.
- R2: While `busy` is high, each cycle with `step` high counts as one step. On the nineteenth step, `busy` falls and `done` rises on the next cycle. `done` lasts exactly one cycle. After eighteen steps, `busy` is still high and `done` is low.
- R3: Cycles with `step` low leave the operation untouched and keep `busy` high. The result does not depend on how many idle cycles come between the steps.
- R4: When `busy` is low, `step` has no effect. `done` stays low, and `quotient`, `remainder`, `ovf` and `div0` keep their values.
- R5: Unsigned 16/16 division applies when `wide`=0, `sgn`=0 and `frac`=0. It uses only `dividend[15:0]` and gives the truncated quotient and the remainder.
- R6: With `wide`=1, the full 32-bit dividend is divided. `ovf` is set when the true quotient does not fit in 16 bits, unsigned (0 to 65535) or signed (-32768 to 32767) as selected by `sgn`. When `ovf` is set, `quotient` and `remainder` are unspecified.
- R7: With `sgn`=1, the operands are two's complement. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend. In 16/16 mode, the dividend is `dividend[15:0]` sign-extended.
- R8: With `frac`=1, the division is signed whatever `sgn` and `wide` are. The dividend is `dividend[15:0]` read as 1.15. The quotient is trunc(x·2^15/d) in 1.15 form and the remainder is x·2^15 − q·d. `ovf` is set when the quotient falls outside -32768 to 32767. A quotient of exactly -1.0 (16'h8000) fits.
- R9: A zero divisor sets `div0` together with `done`; `quotient`, `remainder` and `ovf` are then unspecified. `div0` is cleared when a later division with a nonzero divisor completes.
- R10: After reset, `busy`, `done`, `quotient`, `remainder`, `ovf` and `div0` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the operands and mode, and begin an operation |
| step | input | 1 | Advance the current operation by one step |
| dividend | input | 32 | Dividend; only the low half is used unless `wide`=1 and `frac`=0 |
| divisor | input | 16 | Divisor |
| wide | input | 1 | 1 selects the 32/16 size |
| sgn | input | 1 | 1 selects two's complement operands |
| frac | input | 1 | 1 selects signed 1.15 fractional division |
| quotient | output | 16 | Quotient of the last completed operation |
| remainder | output | 16 | Remainder of the last completed operation |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse after the final step |
| ovf | output | 1 | The quotient of the last operation did not fit |
| div0 | output | 1 | The last operation had a zero divisor |

## Verification
The bench builds the block with its default width of 16. That gives the nineteen-step schedule and puts the exact signed limits within reach: quotients of +32768 and -32768, the 1.15 value -1.0, and the 32/16 overflow border where the upper dividend half equals the divisor. The table pass varies the idle gap between steps from vector to vector. Directed runs then cover:

- long pauses;
- a restart in the middle of an operation;
- steps given while the block is idle;
- the step count at the completion boundary;
- a zero divisor followed by a normal division.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef struct packed {
        logic wide;
        logic sgn;
        logic frac;
    } div_mode_t;

    typedef enum logic [1:0] {
        PH_PREP,
        PH_ITER,
        PH_FIX,
        PH_SIGN
    } div_phase_t;

endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int DW = 16
) (
    input  logic [2*DW-1:0]        a_raw,
    input  logic [DW-1:0]          b_raw,
    input  div_pkg::div_mode_t     mode,
    output logic [DW-1:0]          mag_hi,
    output logic [DW-1:0]          mag_lo,
    output logic [DW-1:0]          dmag,
    output logic                   q_neg,
    output logic                   r_neg,
    output logic                   is_sgn,
    output logic                   pre_ovf,
    output logic                   dz
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] a_eff;
    logic [AW-1:0] a_mag;
    logic          a_neg;
    logic          b_neg;

    always_comb begin
        is_sgn = mode.frac | mode.sgn;
        if (mode.frac) begin
            a_eff = {a_raw[DW-1], a_raw[DW-1:0], {(DW-1){1'b0}}};
        end else if (mode.wide) begin
            a_eff = a_raw;
        end else if (mode.sgn) begin
            a_eff = {{DW{a_raw[DW-1]}}, a_raw[DW-1:0]};
        end else begin
            a_eff = {{DW{1'b0}}, a_raw[DW-1:0]};
        end
        a_neg   = is_sgn & a_eff[AW-1];
        b_neg   = is_sgn & b_raw[DW-1];
        a_mag   = a_neg ? (~a_eff + 1'b1) : a_eff;
        dmag    = b_neg ? (~b_raw + 1'b1) : b_raw;
        mag_hi  = a_mag[AW-1:DW];
        mag_lo  = a_mag[DW-1:0];
        q_neg   = a_neg ^ b_neg;
        r_neg   = a_neg;
        pre_ovf = (mag_hi >= dmag);
        dz      = (b_raw == '0);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int DW = 16
) (
    input  logic [DW+1:0] rem,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] d,
    output logic [DW+1:0] rem_n,
    output logic [DW-1:0] lo_n
);
    localparam int RW = DW + 2;

    logic [RW-1:0] sh;
    logic [RW-1:0] dx;

    always_comb begin
        sh    = {rem[RW-2:0], lo[DW-1]};
        dx    = {2'b00, d};
        rem_n = rem[RW-1] ? (sh + dx) : (sh - dx);
        lo_n  = {lo[DW-2:0], ~rem_n[RW-1]};
    end
endmodule

// File: rtl/div_fin.sv
module div_fin #(
    parameter int DW = 16
) (
    input  logic [DW+1:0] rem,
    input  logic [DW-1:0] qmag,
    input  logic          q_neg,
    input  logic          r_neg,
    input  logic          is_sgn,
    input  logic          pre_ovf,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rmd,
    output logic          ovf
);
    localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

    logic sgn_ovf;

    always_comb begin
        quo     = q_neg ? (~qmag + 1'b1) : qmag;
        rmd     = r_neg ? (~rem[DW-1:0] + 1'b1) : rem[DW-1:0];
        sgn_ovf = is_sgn & (q_neg ? (qmag > HALF) : qmag[DW-1]);
        ovf     = pre_ovf | sgn_ovf;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [2*DW-1:0]   dividend,
    input  logic [DW-1:0]     divisor,
    input  logic              wide,
    input  logic              sgn,
    input  logic              frac,
    output logic [DW-1:0]     quotient,
    output logic [DW-1:0]     remainder,
    output logic              busy,
    output logic              done,
    output logic              ovf,
    output logic              div0
);
    import div_pkg::*;

    localparam int STEPS = DW + 3;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int RW    = DW + 2;
    localparam logic [CW-1:0] IT_LAST = CW'(DW);
    localparam logic [CW-1:0] FIX_AT  = CW'(DW + 1);
    localparam logic [CW-1:0] SIGN_AT = CW'(DW + 2);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CW-1:0]     cnt;
        logic [2*DW-1:0]   a;
        logic [DW-1:0]     b;
        div_mode_t         mode;
        logic [RW-1:0]     rem;
        logic [DW-1:0]     lo;
        logic [DW-1:0]     dmag;
        logic              q_neg;
        logic              r_neg;
        logic              is_sgn;
        logic              povf;
        logic              dz;
        logic [DW-1:0]     quo;
        logic [DW-1:0]     rmd;
        logic              ovf;
        logic              dzo;
    } state_t;

    state_t     st_q, st_d;
    div_phase_t phase;

    logic [DW-1:0] p_hi, p_lo, p_dmag;
    logic          p_qneg, p_rneg, p_sgn, p_povf, p_dz;
    logic [RW-1:0] s_rem;
    logic [DW-1:0] s_lo;
    logic [DW-1:0] f_quo, f_rmd;
    logic          f_ovf;

    div_prep #(.DW(DW)) u_prep (
        .a_raw   (st_q.a),
        .b_raw   (st_q.b),
        .mode    (st_q.mode),
        .mag_hi  (p_hi),
        .mag_lo  (p_lo),
        .dmag    (p_dmag),
        .q_neg   (p_qneg),
        .r_neg   (p_rneg),
        .is_sgn  (p_sgn),
        .pre_ovf (p_povf),
        .dz      (p_dz)
    );

    div_step #(.DW(DW)) u_step (
        .rem   (st_q.rem),
        .lo    (st_q.lo),
        .d     (st_q.dmag),
        .rem_n (s_rem),
        .lo_n  (s_lo)
    );

    div_fin #(.DW(DW)) u_fin (
        .rem     (st_q.rem),
        .qmag    (st_q.lo),
        .q_neg   (st_q.q_neg),
        .r_neg   (st_q.r_neg),
        .is_sgn  (st_q.is_sgn),
        .pre_ovf (st_q.povf),
        .quo     (f_quo),
        .rmd     (f_rmd),
        .ovf     (f_ovf)
    );

    always_comb begin
        if (st_q.cnt == '0) begin
            phase = PH_PREP;
        end else if (st_q.cnt <= IT_LAST) begin
            phase = PH_ITER;
        end else if (st_q.cnt == FIX_AT) begin
            phase = PH_FIX;
        end else begin
            phase = PH_SIGN;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.a    = dividend;
            st_d.b    = divisor;
            st_d.mode = '{wide: wide, sgn: sgn, frac: frac};
        end else if (st_q.busy && step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            unique case (phase)
                PH_PREP: begin
                    st_d.rem    = {2'b00, p_hi};
                    st_d.lo     = p_lo;
                    st_d.dmag   = p_dmag;
                    st_d.q_neg  = p_qneg;
                    st_d.r_neg  = p_rneg;
                    st_d.is_sgn = p_sgn;
                    st_d.povf   = p_povf;
                    st_d.dz     = p_dz;
                end
                PH_ITER: begin
                    st_d.rem = s_rem;
                    st_d.lo  = s_lo;
                end
                PH_FIX: begin
                    if (st_q.rem[RW-1]) begin
                        st_d.rem = st_q.rem + {2'b00, st_q.dmag};
                    end
                end
                PH_SIGN: begin
                    st_d.quo  = f_quo;
                    st_d.rmd  = f_rmd;
                    st_d.ovf  = f_ovf;
                    st_d.dzo  = st_q.dz;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.cnt  = '0;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quotient  = st_q.quo;
    assign remainder = st_q.rmd;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign ovf       = st_q.ovf;
    assign div0      = st_q.dzo;

    logic [CW-1:0] cnt_w;
    logic [RW-1:0] rem_w;
    logic [DW-1:0] braw_w;
    assign cnt_w  = st_q.cnt;
    assign rem_w  = st_q.rem;
    assign braw_w = st_q.b;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_w < CW'(STEPS))); // R2
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step && !start) |=> busy && $stable(cnt_w) && $stable(rem_w)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !done && $stable(quotient) && $stable(remainder) && $stable(ovf)); // R4
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div0 == (braw_w == '0))); // R9

endmodule

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
    localparam int DW = 16;
    localparam int NV = 18;
    localparam int VW = 84;

    // {dividend, divisor, {wide,sgn,frac}, exp_q, exp_r, exp_ovf}
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'hABCD0064, 16'h0007, 3'b000, 16'h000E, 16'h0002, 1'b0}, // R5 upper half ignored
        {32'h0000FF9C, 16'h0007, 3'b010, 16'hFFF2, 16'hFFFE, 1'b0}, // R7
        {32'h00000064, 16'hFFF9, 3'b010, 16'hFFF2, 16'h0002, 1'b0}, // R7
        {32'h1234FF9C, 16'hFFF9, 3'b010, 16'h000E, 16'hFFFE, 1'b0}, // R7
        {32'h00010000, 16'h0002, 3'b100, 16'h8000, 16'h0000, 1'b0}, // R6
        {32'h000F4240, 16'h03E8, 3'b100, 16'h03E8, 16'h0000, 1'b0}, // R6
        {32'h00020000, 16'h0002, 3'b100, 16'h0000, 16'h0000, 1'b1}, // R6 overflow
        {32'hFFF0BDC0, 16'h03E8, 3'b110, 16'hFC18, 16'h0000, 1'b0}, // R6 R7
        {32'h00008000, 16'h0001, 3'b110, 16'h0000, 16'h0000, 1'b1}, // R6 +32768
        {32'hFFFF8000, 16'h0001, 3'b110, 16'h8000, 16'h0000, 1'b0}, // R6 -32768
        {32'h00002000, 16'h4000, 3'b001, 16'h4000, 16'h0000, 1'b0}, // R8
        {32'h0000E000, 16'h4000, 3'b101, 16'hC000, 16'h0000, 1'b0}, // R8 wide ignored
        {32'h00004000, 16'h2000, 3'b001, 16'h0000, 16'h0000, 1'b1}, // R8 overflow
        {32'h0000C000, 16'h4000, 3'b001, 16'h8000, 16'h0000, 1'b0}, // R8 -1.0
        {32'h0000FFFF, 16'h0001, 3'b000, 16'hFFFF, 16'h0000, 1'b0}, // R5
        {32'h00000001, 16'h0003, 3'b001, 16'h2AAA, 16'h0002, 1'b0}, // R8
        {32'h00008000, 16'hFFFF, 3'b010, 16'h0000, 16'h0000, 1'b1}, // R7 overflow
        {32'h0000FFFF, 16'h0100, 3'b000, 16'h00FF, 16'h00FF, 1'b0}  // R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          step = 1'b0;
    logic [31:0]   dividend = '0;
    logic [15:0]   divisor = '0;
    logic          wide = 1'b0, sgn = 1'b0, frac = 1'b0;
    logic [15:0]   quotient, remainder;
    logic          busy, done, ovf, div0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    seq_divider #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .dividend(dividend), .divisor(divisor),
        .wide(wide), .sgn(sgn), .frac(frac),
        .quotient(quotient), .remainder(remainder),
        .busy(busy), .done(done), .ovf(ovf), .div0(div0)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung act=%0d exp<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic begin_op(input logic [31:0] a, input logic [15:0] b, input logic [2:0] m);
        @(negedge clk);
        dividend = a; divisor = b;
        {wide, sgn, frac} = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = 32'hDEAD_BEEF; divisor = 16'h5A5A;
    endtask

    task automatic do_steps(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            repeat (gap) @(negedge clk);
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
        end
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [15:0]   q_keep;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 quotient", quotient, 0);
        chk("R10 remainder", remainder, 0);
        chk("R10 flags", {ovf, div0}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            begin_op(v[83:52], v[51:36], v[35:33]);
            do_steps(19, i % 3);
            chk("R2 done after 19 steps", {done, busy}, 2'b10);
            chk("R6 R7 R8 ovf", ovf, v[0]);
            chk("R9 div0 clear", div0, 0);
            if (!v[0]) begin
                chk("R5 R6 R7 R8 quotient", quotient, v[32:17]);
                chk("R5 R6 R7 R8 remainder", remainder, v[16:1]);
            end
        end

        // R2 boundary: 18 steps leave busy, 19th completes, done lasts one cycle
        begin_op(32'd100, 16'd7, 3'b000);
        chk("R1 busy after start", {busy, done}, 2'b10);
        do_steps(18, 0);
        chk("R2 still busy after 18", {busy, done}, 2'b10);
        do_steps(1, 0);
        chk("R2 done on 19th", {busy, done}, 2'b01);
        @(negedge clk);
        chk("R2 done single cycle", done, 0);

        // R3 long pauses give the same result
        begin_op(32'hFFF0BDC0, 16'h03E8, 3'b110);
        do_steps(7, 0);
        repeat (60) @(negedge clk);
        chk("R3 busy held in pause", {busy, done}, 2'b10);
        do_steps(12, 23);
        chk("R3 quotient after pauses", quotient, 16'hFC18);
        chk("R3 remainder after pauses", remainder, 16'h0000);

        // R1 restart in the middle
        begin_op(32'd1000, 16'd3, 3'b000);
        do_steps(10, 1);
        begin_op(32'd200, 16'd9, 3'b000);
        do_steps(18, 0);
        chk("R1 restart needs full count", {busy, done}, 2'b10);
        do_steps(1, 0);
        chk("R1 restart quotient", quotient, 16'd22);
        chk("R1 restart remainder", remainder, 16'd2);

        // R1 start beats step in the same cycle
        @(negedge clk);
        dividend = 32'd50; divisor = 16'd5; {wide, sgn, frac} = 3'b000;
        start = 1'b1; step = 1'b1;
        @(negedge clk);
        start = 1'b0; step = 1'b0;
        do_steps(18, 0);
        chk("R1 start wins over step", {busy, done}, 2'b10);
        do_steps(1, 0);
        chk("R1 start wins quotient", quotient, 16'd10);

        // R4 steps while idle are ignored
        q_keep = quotient;
        do_steps(25, 0);
        chk("R4 idle busy", {busy, done}, 2'b00);
        chk("R4 idle quotient", quotient, q_keep);

        // R9 zero divisor, then recovery
        begin_op(32'd1234, 16'd0, 3'b010);
        do_steps(19, 2);
        chk("R9 div0 set", {div0, done}, 2'b11);
        begin_op(32'd81, 16'd9, 3'b000);
        do_steps(19, 0);
        chk("R9 div0 cleared", div0, 0);
        chk("R9 recovery quotient", quotient, 16'd9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule